// File: doc/BRIEF.md
# Boundary-Scan Test Port

This block is the serial test port of a chip. A tester drives a test clock, a mode-select line, serial data in and an active-low test reset; the block returns serial data out with its own output enable. Inside sit the sixteen-state test controller, an eight-bit instruction register, a one-bit bypass register, a 32-bit identification register and a boundary register. The boundary register covers `NUM_IN` input pads and `NUM_OUT` output pads, each output pad having one data cell and one enable cell.

On the core side the block sits between the functional logic and the pad drivers. In normal operation the core's output data and output enables pass straight through to the pads. Three instructions take the pads over. One drives them from the boundary update latches while scanning the boundary chain. One drives them from those latches while scanning through bypass. One turns every output enable off. Every register is loaded at its most significant bit, and its least significant bit appears on the serial output. The serial output changes only on the falling test-clock edge.

Top module: `scan_port`

## Requirements
- R1: With `test_rst_n` low at a rising `test_clk` edge, the controller enters Test-Logic-Reset and the instruction becomes the identification code (8'h02). While reset is held and after it is released, `scan_out_en` is 0 and the pads follow `core_out`/`core_oe`.
- R2: Five rising edges with `mode_sel` high bring the controller to Test-Logic-Reset from any state, which again selects the identification register.
- R3: A data scan with no instruction scan since reset returns the `ID_VALUE` constant (bit 0 equal to 1), least significant bit first.
- R4: In Capture-IR the instruction register loads 8'h01, so an instruction scan returns the bits 1,0,0,0,0,0,0,0 in that order. The new code is loaded through bit 7.
- R5: Code 8'hFF selects the one-bit bypass path. It captures 0, delays serial data by one bit, and leaves the pads following the core.
- R6: Any code other than 8'hFF, 8'h00, 8'h01, 8'h02, 8'h04 and 8'h08 behaves as code 8'hFF.
- R7: Code 8'h01 selects the boundary register and leaves the pads following the core. Capture-DR loads pad inputs into bits [NUM_IN-1:0], core output data into the next NUM_OUT bits and core output enables into the top NUM_OUT bits. Update-DR loads the update latches, which hold the value through later instructions.
- R8: Code 8'h00 selects the boundary register and drives `pad_out`/`pad_oe` from the output-data and output-enable fields of the update latches. Its Capture-DR loads the pad inputs into the low boundary bits.
- R9: Code 8'h04 drives the pads from the update latches and selects the one-bit bypass path.
- R10: Code 8'h08 forces every bit of `pad_oe` to 0 and selects the one-bit bypass path.
- R11: `scan_out` changes only on falling `test_clk` edges. `scan_out_en` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Active-low test reset, sampled on the rising edge |
| mode_sel | input | 1 | Controller mode select, sampled on the rising edge |
| scan_in | input | 1 | Serial data in, sampled on the rising edge |
| scan_out | output | 1 | Serial data out, updated on the falling edge |
| scan_out_en | output | 1 | Serial output enable |
| pad_in | input | NUM_IN | Values arriving at the input pads |
| core_out | input | NUM_OUT | Functional output data from the core |
| core_oe | input | NUM_OUT | Functional output enables from the core |
| pad_out | output | NUM_OUT | Data to the output pad drivers |
| pad_oe | output | NUM_OUT | Enables to the output pad drivers |

## Verification
The bench builds the port with `NUM_IN`=2 and `NUM_OUT`=3, which gives an eight-bit boundary chain. That chain is short next to the 32-bit identification register and the one-bit bypass. Every path therefore shows a distinct delay within one 40-bit scan, and every latch field can be written with a single pattern. An odd, irregular `ID_VALUE` makes a wrong bit order or a missing capture visible.

// File: rtl/scan_pkg.sv
// Shared definitions for the boundary-scan test port: controller states,
// instruction codes and the decode from code to serial path and pad mode.
// Assumes the instruction width is fixed at eight bits.
package scan_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
    localparam logic [IR_W-1:0] OP_EXT_TEST = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
    localparam logic [IR_W-1:0] OP_IDENT    = 8'h02;
    localparam logic [IR_W-1:0] OP_CLAMP    = 8'h04;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 8'h08;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 8'h01;

    typedef enum logic [1:0] {PATH_BYPASS, PATH_IDENT, PATH_BOUNDARY} dr_path_e;
    typedef enum logic [1:0] {PADS_CORE, PADS_LATCH, PADS_OFF} pad_mode_e;

    typedef struct packed {
        dr_path_e  path;
        pad_mode_e pads;
    } op_decode_t;

    // Map an instruction code to its data path and pad mode; unknown codes act as bypass.
    function automatic op_decode_t decode_op(input logic [IR_W-1:0] op);
        op_decode_t d;
        d.path = PATH_BYPASS;
        d.pads = PADS_CORE;
        case (op)
            OP_EXT_TEST: begin d.path = PATH_BOUNDARY; d.pads = PADS_LATCH; end
            OP_SAMPLE:   d.path = PATH_BOUNDARY;
            OP_IDENT:    d.path = PATH_IDENT;
            OP_CLAMP:    d.pads = PADS_LATCH;
            OP_HIGHZ:    d.pads = PADS_OFF;
            default:     ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
// Sixteen-state test controller. Advances on the rising test clock from the
// mode-select input; the synchronous active-low reset forces Test-Logic-Reset.
module scan_fsm
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    output tap_state_e state_o
);

    tap_state_e state_q, state_d;

    // Next-state table of the controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = mode_sel ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = mode_sel ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = mode_sel ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = mode_sel ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = mode_sel ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = mode_sel ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = mode_sel ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = mode_sel ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = mode_sel ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = mode_sel ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = mode_sel ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = mode_sel ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = mode_sel ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = mode_sel ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = mode_sel ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = mode_sel ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // Run of consecutive high mode-select edges, saturating at five (checking aid).
    logic [2:0] ones_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_sel) ones_q <= '0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_q == 3'd5) |-> (state_q == ST_RESET)); // R2

endmodule

// File: rtl/scan_ir.sv
// Instruction register: a shift stage loaded through its MSB and an update
// stage holding the active code. Test-Logic-Reset forces the identification code.
module scan_ir
    import scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            scan_in,
    output logic            ir_lsb,
    output logic [IR_W-1:0] op_o,
    output op_decode_t      dec_o
);

    logic [IR_W-1:0] sr_q, op_q;

    // Shift stage: capture the fixed pattern, then shift toward the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sr_q <= '0;
        else if (state == ST_CAP_IR) sr_q <= IR_CAPTURE;
        else if (state == ST_SH_IR)  sr_q <= {scan_in, sr_q[IR_W-1:1]};
    end

    // Update stage: identification code in reset, shift contents on Update-IR.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_RESET) op_q <= OP_IDENT;
        else if (state == ST_UPD_IR)     op_q <= sr_q;
    end

    assign ir_lsb = sr_q[0];
    assign op_o   = op_q;
    assign dec_o  = decode_op(op_q);

    AST_RESET_LOADS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |=> (op_q == OP_IDENT)); // R1
    AST_IR_ENTERS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SH_IR) |=> (sr_q[IR_W-1] == $past(scan_in))); // R4

endmodule

// File: rtl/scan_dr.sv
// Bypass and identification data registers. Each captures its constant in
// Capture-DR and shifts through its MSB when selected. Assumes ID_VALUE is odd.
module scan_dr
    import scan_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4B1D_3C97
) (
    input  logic       clk,
    input  logic       rst_n,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       scan_in,
    output logic       byp_lsb,
    output logic       id_lsb
);

    localparam int ID_W = $bits(ID_VALUE);

    logic            byp_q;
    logic [ID_W-1:0] id_q;

    // Bypass cell: capture zero, then pass one bit per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) byp_q <= 1'b0;
        else if (path == PATH_BYPASS) begin
            if (state == ST_CAP_DR)     byp_q <= 1'b0;
            else if (state == ST_SH_DR) byp_q <= scan_in;
        end
    end

    // Identification register: capture the constant, then shift it out.
    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= ID_VALUE;
        else if (path == PATH_IDENT) begin
            if (state == ST_CAP_DR)     id_q <= ID_VALUE;
            else if (state == ST_SH_DR) id_q <= {scan_in, id_q[ID_W-1:1]};
        end
    end

    assign byp_lsb = byp_q;
    assign id_lsb  = id_q[0];

    AST_BYPASS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SH_DR && path == PATH_BYPASS) |=> (byp_q == $past(scan_in))); // R5

endmodule

// File: rtl/scan_bsr.sv
// Boundary register with update latches. Cell order from the serial output:
// inputs, then output data, then output enables. Updates only on Update-DR
// while the boundary path is selected.
module scan_bsr
    import scan_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  dr_path_e           path,
    input  logic               scan_in,
    input  logic [NUM_IN-1:0]  pad_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic               bsr_lsb,
    output logic [NUM_OUT-1:0] lat_out,
    output logic [NUM_OUT-1:0] lat_oe
);

    localparam int LEN    = NUM_IN + 2 * NUM_OUT;
    localparam int OUT_LO = NUM_IN;
    localparam int OE_LO  = NUM_IN + NUM_OUT;

    logic [LEN-1:0] cap_vec, sr_q, lat_q;
    logic           sel;

    assign sel = (path == PATH_BOUNDARY);

    // Per-cell capture source, chosen by the cell's position in the chain.
    for (genvar g = 0; g < LEN; g++) begin : g_cell
        if (g < OUT_LO) begin : g_in
            assign cap_vec[g] = pad_in[g];
        end else if (g < OE_LO) begin : g_dat
            assign cap_vec[g] = core_out[g - OUT_LO];
        end else begin : g_en
            assign cap_vec[g] = core_oe[g - OE_LO];
        end
    end

    // Shift stage: capture the pad and core view, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else if (sel) begin
            if (state == ST_CAP_DR)     sr_q <= cap_vec;
            else if (state == ST_SH_DR) sr_q <= {scan_in, sr_q[LEN-1:1]};
        end
    end

    // Update latches: load on Update-DR, hold across later instructions.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lat_q <= '0;
        else if (sel && state == ST_UPD_DR) lat_q <= sr_q;
    end

    assign bsr_lsb = sr_q[0];
    assign lat_out = lat_q[OE_LO-1:OUT_LO];
    assign lat_oe  = lat_q[LEN-1:OE_LO];

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_UPD_DR) |=> $stable(lat_q)); // R7

endmodule

// File: rtl/scan_port.sv
// Top of the boundary-scan test port. Joins controller, instruction and data
// registers, selects the serial output on the falling edge and gates the pads.
// Assumes pad drivers honour pad_oe for high impedance.
module scan_port
    import scan_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_OUT  = 4,
    parameter logic [31:0] ID_VALUE = 32'h4B1D_3C97
) (
    input  logic               test_clk,
    input  logic               test_rst_n,
    input  logic               mode_sel,
    input  logic               scan_in,
    output logic               scan_out,
    output logic               scan_out_en,
    input  logic [NUM_IN-1:0]  pad_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pad_out,
    output logic [NUM_OUT-1:0] pad_oe
);

    tap_state_e         state;
    op_decode_t         dec;
    logic [IR_W-1:0]    op;
    logic               ir_lsb, byp_lsb, id_lsb, bsr_lsb, dr_lsb;
    logic [NUM_OUT-1:0] lat_out, lat_oe;

    scan_fsm i_fsm (
        .clk(test_clk), .rst_n(test_rst_n), .mode_sel(mode_sel), .state_o(state)
    );

    scan_ir i_ir (
        .clk(test_clk), .rst_n(test_rst_n), .state(state), .scan_in(scan_in),
        .ir_lsb(ir_lsb), .op_o(op), .dec_o(dec)
    );

    scan_dr #(.ID_VALUE(ID_VALUE)) i_dr (
        .clk(test_clk), .rst_n(test_rst_n), .state(state), .path(dec.path),
        .scan_in(scan_in), .byp_lsb(byp_lsb), .id_lsb(id_lsb)
    );

    scan_bsr #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) i_bsr (
        .clk(test_clk), .rst_n(test_rst_n), .state(state), .path(dec.path),
        .scan_in(scan_in), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .bsr_lsb(bsr_lsb), .lat_out(lat_out), .lat_oe(lat_oe)
    );

    // Pick the LSB of the data register the active instruction selects.
    always_comb begin
        unique case (dec.path)
            PATH_IDENT:    dr_lsb = id_lsb;
            PATH_BOUNDARY: dr_lsb = bsr_lsb;
            default:       dr_lsb = byp_lsb;
        endcase
    end

    // Serial output stage on the falling edge, enabled only in the shift states.
    always_ff @(negedge test_clk) begin
        if (!test_rst_n) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else if (state == ST_SH_IR) begin
            scan_out    <= ir_lsb;
            scan_out_en <= 1'b1;
        end else if (state == ST_SH_DR) begin
            scan_out    <= dr_lsb;
            scan_out_en <= 1'b1;
        end else begin
            scan_out_en <= 1'b0;
        end
    end

    // Pad gating by instruction mode.
    always_comb begin
        unique case (dec.pads)
            PADS_LATCH: begin pad_out = lat_out;  pad_oe = lat_oe;  end
            PADS_OFF:   begin pad_out = core_out; pad_oe = '0;      end
            default:    begin pad_out = core_out; pad_oe = core_oe; end
        endcase
    end

    logic unused_op;
    assign unused_op = ^op;

    AST_OUT_EN_SHIFT_ONLY: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        scan_out_en |-> (state == ST_SH_IR || state == ST_SH_DR)); // R11

endmodule

// File: tb/test_scan_port.sv
module test_scan_port;

    localparam int          NI  = 2;
    localparam int          NO  = 3;
    localparam int          L   = NI + 2 * NO;
    localparam logic [31:0] IDV = 32'h5EA1_C0DB;
    localparam int          SN  = 40;

    logic          test_clk = 1'b0;
    logic          test_rst_n, mode_sel, scan_in;
    logic          scan_out, scan_out_en;
    logic [NI-1:0] pad_in;
    logic [NO-1:0] core_out, core_oe, pad_out, pad_oe;

    int checks = 0, fails = 0, edge_err = 0, oe_err = 0;
    bit done = 0;
    logic [L-1:0] latch_m = '0;

    always #5 test_clk = ~test_clk;

    scan_port #(.NUM_IN(NI), .NUM_OUT(NO), .ID_VALUE(IDV)) i_scan_port (
        .test_clk(test_clk), .test_rst_n(test_rst_n), .mode_sel(mode_sel),
        .scan_in(scan_in), .scan_out(scan_out), .scan_out_en(scan_out_en),
        .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Entries: {code, path 0=bypass 1=ident 2=boundary, pads 0=core 1=latch 2=off}
    localparam logic [11:0] VEC [0:6] = '{
        {8'h08, 2'd0, 2'd2},   // R10
        {8'h00, 2'd2, 2'd1},   // R8
        {8'h01, 2'd2, 2'd0},   // R7
        {8'h02, 2'd1, 2'd0},   // R3
        {8'h04, 2'd0, 2'd1},   // R9 (latch holds preload from R7 entry)
        {8'hFF, 2'd0, 2'd0},   // R5
        {8'h55, 2'd0, 2'd0}    // R6
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic q);
        mode_sel = m;
        scan_in  = d;
        q = scan_out;
        @(posedge test_clk);
        #1;
        if (scan_out !== q) edge_err++;
        @(negedge test_clk);
        #1;
    endtask

    task automatic ir_load(input logic [7:0] op, output logic [7:0] cap);
        logic q;
        step(1, 0, q); step(1, 0, q); step(0, 0, q); step(0, 0, q);
        for (int i = 0; i < 8; i++) begin
            if (!scan_out_en) oe_err++;
            step(i == 7, op[i], cap[i]);
        end
        step(1, 0, q); step(0, 0, q);
    endtask

    task automatic dr_scan(input logic [SN-1:0] din, input int n, output logic [SN-1:0] dout);
        logic q;
        dout = '0;
        step(1, 0, q); step(0, 0, q); step(0, 0, q);
        for (int i = 0; i < n; i++) begin
            if (!scan_out_en) oe_err++;
            step(i == n - 1, din[i], dout[i]);
        end
        step(1, 0, q); step(0, 0, q);
    endtask

    task automatic do_reset();
        logic q;
        test_rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(0, 0, q);
        test_rst_n = 1'b1;
        step(0, 0, q);
        latch_m = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]    cap;
        logic [SN-1:0] din, dout;
        logic          q;
        mode_sel = 1'b1; scan_in = 1'b0; test_rst_n = 1'b0;
        pad_in = 2'b10; core_out = 3'b101; core_oe = 3'b011;
        @(negedge test_clk); #1;
        do_reset();

        // R1: reset state
        check("R1 out_en", scan_out_en, 0);
        check("R1 pad_out", pad_out, core_out);
        check("R1 pad_oe", pad_oe, core_oe);

        // R3: identification value after reset
        dr_scan('0, 32, dout);
        check("R3 ident", dout[31:0], IDV);
        check("R3 ident lsb", dout[0], 1);
        check("R11 idle out_en", scan_out_en, 0);

        // R4: instruction capture pattern
        ir_load(8'hFF, cap);
        check("R4 capture", cap, 8'h01);

        // Table walk: path length and pad mode per code
        for (int e = 0; e < 7; e++) begin
            logic [7:0] op;
            int         pth, pm, len, bad;
            op  = VEC[e][11:4];
            pth = int'(VEC[e][3:2]);
            pm  = int'(VEC[e][1:0]);
            len = (pth == 0) ? 1 : (pth == 1) ? 32 : L;
            ir_load(op, cap);
            if (pm == 1) begin
                check($sformatf("R8/R9 pads op=%h", op), {pad_out, pad_oe},
                      {latch_m[NI +: NO], latch_m[NI+NO +: NO]});
            end else if (pm == 2) begin
                check("R10 pad_oe off", pad_oe, 0);
            end else begin
                check($sformatf("R5/R6/R7 pads core op=%h", op), {pad_out, pad_oe},
                      {core_out, core_oe});
            end
            din = {8'hC3, 32'h9A5E_1B72} ^ {SN{e[0]}};
            dr_scan(din, SN, dout);
            bad = 0;
            for (int k = len; k < SN; k++) if (dout[k] !== din[k - len]) bad++;
            check($sformatf("R5/R6/R8/R9/R10 path length op=%h len=%0d", op, len), bad, 0);
            if (pth == 0) check("R5 bypass captures 0", dout[0], 0);
            if (pth == 2) latch_m = din[SN-L +: L];
        end

        // R7: sample captures pads and core
        core_out = 3'b110; core_oe = 3'b100; pad_in = 2'b01;
        ir_load(8'h01, cap);
        dr_scan('0, L, dout);
        check("R7 sample capture", dout[L-1:0], {core_oe, core_out, pad_in});
        check("R7 pads follow core", {pad_out, pad_oe}, {core_out, core_oe});
        latch_m = '0;

        // R8: external test captures new pad inputs
        pad_in = 2'b11;
        ir_load(8'h00, cap);
        check("R8 pads from latch", {pad_out, pad_oe}, {latch_m[NI +: NO], latch_m[NI+NO +: NO]});
        dr_scan({32'h0, 8'b10100100}, L, dout);
        check("R8 capture pad_in", dout[NI-1:0], pad_in);
        check("R8 pads after update", {pad_out, pad_oe}, {3'b001, 3'b101});

        // R2: five high mode-select edges from Shift-DR
        ir_load(8'hFF, cap);
        step(1, 0, q); step(0, 0, q); step(0, 0, q);
        for (int i = 0; i < 5; i++) step(1, 0, q);
        check("R2 pads core", {pad_out, pad_oe}, {core_out, core_oe});
        step(0, 0, q);
        dr_scan('0, 32, dout);
        check("R2 ident after tms reset", dout[31:0], IDV);

        // R1: reset in the middle of an instruction scan
        ir_load(8'h04, cap);
        step(1, 0, q); step(1, 0, q); step(0, 0, q); step(0, 0, q);
        step(0, 1, q); step(0, 1, q);
        test_rst_n = 1'b0;
        step(0, 0, q);
        check("R1 out_en in reset", scan_out_en, 0);
        test_rst_n = 1'b1;
        step(0, 0, q);
        check("R1 pads core after reset", {pad_out, pad_oe}, {core_out, core_oe});
        dr_scan('0, 32, dout);
        check("R1 ident after reset", dout[31:0], IDV);

        // R11: output timing and enable
        check("R11 no change at rising edge", edge_err, 0);
        check("R11 enabled in shift", oe_err, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule